// File: doc/BRIEF.md
# Fetch PC Sequencer with Delay-Slot Tracking

This block keeps the program counter for a 32-bit five-stage pipeline that has a single branch delay slot. A registered fetch enable comes up one edge after reset is released. While that enable is low the PC is held at the boot address, zero by default. Once fetching, the PC moves on by one word per unstalled edge. When decode reports a taken branch, the PC loads the supplied target instead.

The decoder resolves a branch while the instruction that follows it is being fetched. So the redirect always lands after exactly one sequential fetch, and that fetch is the delay slot. The block also holds two pieces of pipeline bookkeeping. The first is a decode-side flag that tells decode whether its current instruction is a delay slot. The second is the execute-stage copy of the link address and of the in-slot marker.

Back-pressure comes only from the six-bit stall vector. Bit 0 freezes fetch. Bit 2 freezes decode. When bit 2 is set and bit 3 is clear, a bubble is inserted into execute. The interface has no valid/ready pair, because every input is a per-cycle control level from the pipeline controller and the decoder.

Top module: `fetch_pc_seq`

## Requirements
- R1: The fetch enable is 0 on every edge where reset is high, and it is 1 from the first rising edge after reset is released.
- R2: On an edge where reset is high or the fetch enable was 0, the PC becomes 0x00000000.
- R3: With the enable high, stall bit 0 clear and no taken branch, the PC advances by 4 on each edge.
- R4: With stall bit 0 set, the PC keeps its value, even while a taken branch is presented.
- R5: With the enable high, stall bit 0 clear and the taken flag high, the PC loads the target on that edge. The PC that was current when the flag rose (branch address + 4, the delay slot) is the only fetch between the branch and its target.
- R6: With stall bit 2 clear, the decode-side in-slot flag loads the decoder's next-is-slot input.
- R7: With stall bit 2 set, the decode-side in-slot flag keeps its value. This includes the bubble case.
- R8: With stall bit 2 clear, the execute link address and execute in-slot flag load the decode-stage values.
- R9: With stall bit 2 set and bit 3 clear, the execute link address becomes 0 and the execute in-slot flag becomes 0.
- R10: With stall bits 2 and 3 both set, both execute fields keep their values.
- R11: Reset clears the decode-side flag, the execute link address and the execute in-slot flag to 0.
- R12: A taken branch held across a fetch stall is not lost: the PC loads the target on the first unstalled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 6 | Stall vector: bit 0 fetch, bit 2 decode, bit 3 execute |
| br_taken | input | 1 | Decode has resolved a taken branch or jump |
| br_target | input | 32 | Redirect address |
| nxt_in_slot | input | 1 | Decode marks the following instruction as a delay slot |
| id_link_addr | input | 32 | Return address produced by decode |
| id_in_slot | input | 1 | Decode's instruction is a delay slot |
| pc | output | 32 | Current fetch address |
| imem_en | output | 1 | Instruction memory enable |
| dec_in_slot | output | 1 | Registered in-slot flag returned to decode |
| ex_link_addr | output | 32 | Execute-stage link address |
| ex_in_slot | output | 1 | Execute-stage in-slot flag |

## Verification
Every output is registered, so each result is due on the first rising edge after the inputs that cause it. The PC, the enable, both slot flags and the link address all follow this one-edge rule. The bench drives inputs on the falling edge and works out the expected next state from those inputs and its own previous expectation. It compares on the following falling edge. A redirect stalled for several cycles is checked on the edge where stall bit 0 finally clears.

// File: rtl/fetch_pc_pkg.sv
package fetch_pc_pkg;
  // what the fetch register does on the next edge
  typedef enum logic [1:0] {
    PC_ACT_CLEAR,
    PC_ACT_HOLD,
    PC_ACT_SEQ,
    PC_ACT_JUMP
  } pc_act_e;

  // what the decode/execute slot register does on the next edge
  typedef enum logic [1:0] {
    EX_ACT_LOAD,
    EX_ACT_BUBBLE,
    EX_ACT_HOLD
  } ex_act_e;
endpackage

// File: rtl/pc_act_sel.sv
module pc_act_sel
  import fetch_pc_pkg::*;
(
  input  logic    fetch_on,
  input  logic    stall_fetch,
  input  logic    jump_req,
  output pc_act_e act
);
  always_comb begin
    if (!fetch_on)        act = PC_ACT_CLEAR;
    else if (stall_fetch) act = PC_ACT_HOLD;
    else if (jump_req)    act = PC_ACT_JUMP;
    else                  act = PC_ACT_SEQ;
  end
endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg
  import fetch_pc_pkg::*;
#(
  parameter int          AW      = 32,
  parameter int          STEP    = 4,
  parameter logic [31:0] BOOT_PC = 32'h0
) (
  input  logic          clk,
  input  logic          rst,
  input  pc_act_e       act,
  input  logic [AW-1:0] jump_tgt,
  output logic [AW-1:0] pc,
  output logic          fetch_on
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  localparam logic [AW-1:0] BOOT_V = AW'(BOOT_PC);

  always_ff @(posedge clk) begin
    if (rst) fetch_on <= 1'b0;
    else     fetch_on <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= BOOT_V;
    end else begin
      unique case (act)
        PC_ACT_CLEAR: pc <= BOOT_V;
        PC_ACT_HOLD:  pc <= pc;
        PC_ACT_JUMP:  pc <= jump_tgt;
        default:      pc <= pc + STEP_V;
      endcase
    end
  end
endmodule

// File: rtl/slot_track_reg.sv
module slot_track_reg
  import fetch_pc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall_dec,
  input  logic          stall_exe,
  input  logic          nxt_in_slot,
  input  logic [AW-1:0] id_link_addr,
  input  logic          id_in_slot,
  output logic          dec_in_slot,
  output logic [AW-1:0] ex_link_addr,
  output logic          ex_in_slot
);
  ex_act_e ex_act;

  always_comb begin
    if (!stall_dec)     ex_act = EX_ACT_LOAD;
    else if (!stall_exe) ex_act = EX_ACT_BUBBLE;
    else                ex_act = EX_ACT_HOLD;
  end

  // decode-side flag: follows decoder unless decode is frozen
  always_ff @(posedge clk) begin
    if (rst)             dec_in_slot <= 1'b0;
    else if (!stall_dec) dec_in_slot <= nxt_in_slot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_link_addr <= '0;
      ex_in_slot   <= 1'b0;
    end else begin
      unique case (ex_act)
        EX_ACT_LOAD: begin
          ex_link_addr <= id_link_addr;
          ex_in_slot   <= id_in_slot;
        end
        EX_ACT_BUBBLE: begin
          ex_link_addr <= '0;
          ex_in_slot   <= 1'b0;
        end
        default: begin
          ex_link_addr <= ex_link_addr;
          ex_in_slot   <= ex_in_slot;
        end
      endcase
    end
  end
endmodule

// File: rtl/fetch_pc_seq.sv
module fetch_pc_seq
  import fetch_pc_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          STALL_W  = 6,
  parameter int          STEP     = 4,
  parameter logic [31:0] BOOT_PC  = 32'h0,
  parameter int          FETCH_BIT = 0,
  parameter int          DEC_BIT   = 2,
  parameter int          EXE_BIT   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STALL_W-1:0] stall,
  input  logic               br_taken,
  input  logic [AW-1:0]      br_target,
  input  logic               nxt_in_slot,
  input  logic [AW-1:0]      id_link_addr,
  input  logic               id_in_slot,
  output logic [AW-1:0]      pc,
  output logic               imem_en,
  output logic               dec_in_slot,
  output logic [AW-1:0]      ex_link_addr,
  output logic               ex_in_slot
);
  logic    stall_fetch, stall_dec, stall_exe;
  logic    unused_stall;
  pc_act_e pc_act;

  assign stall_fetch  = stall[FETCH_BIT];
  assign stall_dec    = stall[DEC_BIT];
  assign stall_exe    = stall[EXE_BIT];
  assign unused_stall = ^stall;

  pc_act_sel u_sel (
    .fetch_on    (imem_en),
    .stall_fetch (stall_fetch),
    .jump_req    (br_taken),
    .act         (pc_act)
  );

  fetch_pc_reg #(.AW(AW), .STEP(STEP), .BOOT_PC(BOOT_PC)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .act      (pc_act),
    .jump_tgt (br_target),
    .pc       (pc),
    .fetch_on (imem_en)
  );

  slot_track_reg #(.AW(AW)) u_slot (
    .clk          (clk),
    .rst          (rst),
    .stall_dec    (stall_dec),
    .stall_exe    (stall_exe),
    .nxt_in_slot  (nxt_in_slot),
    .id_link_addr (id_link_addr),
    .id_in_slot   (id_in_slot),
    .dec_in_slot  (dec_in_slot),
    .ex_link_addr (ex_link_addr),
    .ex_in_slot   (ex_in_slot)
  );
endmodule

// File: rtl/fetch_pc_seq_chk.sv
module fetch_pc_seq_chk #(
  parameter int          AW      = 32,
  parameter int          STEP    = 4,
  parameter logic [31:0] BOOT_PC = 32'h0
) (
  input logic          clk,
  input logic          rst,
  input logic          stall_fetch,
  input logic          stall_dec,
  input logic          stall_exe,
  input logic          br_taken,
  input logic [AW-1:0] br_target,
  input logic          nxt_in_slot,
  input logic [AW-1:0] id_link_addr,
  input logic          id_in_slot,
  input logic [AW-1:0] pc,
  input logic          imem_en,
  input logic          dec_in_slot,
  input logic [AW-1:0] ex_link_addr,
  input logic          ex_in_slot
);
  assert_enable_up_R1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> imem_en);

  assert_pc_clear_R2: assert property (@(posedge clk) disable iff (rst)
    !imem_en |=> (pc == AW'(BOOT_PC)));

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
    (imem_en && !stall_fetch && !br_taken) |=> (pc == $past(pc) + AW'(STEP)));

  assert_pc_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (imem_en && stall_fetch) |=> $stable(pc));

  assert_redirect_R5: assert property (@(posedge clk) disable iff (rst)
    (imem_en && !stall_fetch && br_taken) |=> (pc == $past(br_target)));

  assert_dec_load_R6: assert property (@(posedge clk) disable iff (rst)
    !stall_dec |=> (dec_in_slot == $past(nxt_in_slot)));

  assert_dec_hold_R7: assert property (@(posedge clk) disable iff (rst)
    stall_dec |=> $stable(dec_in_slot));

  assert_ex_load_R8: assert property (@(posedge clk) disable iff (rst)
    !stall_dec |=> (ex_link_addr == $past(id_link_addr) && ex_in_slot == $past(id_in_slot)));

  assert_bubble_R9: assert property (@(posedge clk) disable iff (rst)
    (stall_dec && !stall_exe) |=> (ex_link_addr == '0 && !ex_in_slot));

  assert_ex_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (stall_dec && stall_exe) |=> ($stable(ex_link_addr) && $stable(ex_in_slot)));
endmodule

bind fetch_pc_seq fetch_pc_seq_chk #(.AW(AW), .STEP(STEP), .BOOT_PC(BOOT_PC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .stall_fetch  (stall_fetch),
  .stall_dec    (stall_dec),
  .stall_exe    (stall_exe),
  .br_taken     (br_taken),
  .br_target    (br_target),
  .nxt_in_slot  (nxt_in_slot),
  .id_link_addr (id_link_addr),
  .id_in_slot   (id_in_slot),
  .pc           (pc),
  .imem_en      (imem_en),
  .dec_in_slot  (dec_in_slot),
  .ex_link_addr (ex_link_addr),
  .ex_in_slot   (ex_in_slot)
);

// File: tb/fetch_pc_seq_tb_top.sv
`timescale 1ns/1ps
module fetch_pc_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  stall = '0;
  logic        br_taken = 1'b0;
  logic [31:0] br_target = '0;
  logic        nxt_in_slot = 1'b0;
  logic [31:0] id_link_addr = '0;
  logic        id_in_slot = 1'b0;
  logic [31:0] pc;
  logic        imem_en;
  logic        dec_in_slot;
  logic [31:0] ex_link_addr;
  logic        ex_in_slot;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic        e_en  = 1'b0;
  logic [31:0] e_pc  = '0;
  logic        e_dec = 1'b0;
  logic [31:0] e_lnk = '0;
  logic        e_ex  = 1'b0;

  always #2 clk = ~clk;

  fetch_pc_seq dut_i (
    .clk(clk), .rst(rst), .stall(stall), .br_taken(br_taken), .br_target(br_target),
    .nxt_in_slot(nxt_in_slot), .id_link_addr(id_link_addr), .id_in_slot(id_in_slot),
    .pc(pc), .imem_en(imem_en), .dec_in_slot(dec_in_slot),
    .ex_link_addr(ex_link_addr), .ex_in_slot(ex_in_slot)
  );

  function automatic logic [31:0] model_pc(logic r, logic en, logic [31:0] cur,
                                           logic [5:0] s, logic b, logic [31:0] t);
    if (r || !en) return 32'h0;
    if (s[0])     return cur;
    if (b)        return t;
    return cur + 32'd4;
  endfunction

  function automatic string pc_tag(logic r, logic en, logic [5:0] s, logic b);
    if (r || !en) return "R2";
    if (s[0])     return "R4";
    if (b)        return "R5";
    return "R3";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic r, logic [5:0] s, logic b, logic [31:0] t,
                      logic n, logic [31:0] l, logic i);
    logic        n_en, n_dec, n_ex;
    logic [31:0] n_pc, n_lnk;
    string tp, td, tx;
    rst = r; stall = s; br_taken = b; br_target = t;
    nxt_in_slot = n; id_link_addr = l; id_in_slot = i;
    n_en = !r;
    n_pc = model_pc(r, e_en, e_pc, s, b, t);
    tp   = pc_tag(r, e_en, s, b);
    if (r)         begin n_dec = 1'b0;  td = "R11"; end
    else if (s[2]) begin n_dec = e_dec; td = "R7";  end
    else           begin n_dec = n;     td = "R6";  end
    if (r)          begin n_lnk = '0;    n_ex = 1'b0; tx = "R11"; end
    else if (!s[2]) begin n_lnk = l;     n_ex = i;    tx = "R8";  end
    else if (!s[3]) begin n_lnk = '0;    n_ex = 1'b0; tx = "R9";  end
    else            begin n_lnk = e_lnk; n_ex = e_ex; tx = "R10"; end
    @(posedge clk);
    @(negedge clk);
    e_en = n_en; e_pc = n_pc; e_dec = n_dec; e_lnk = n_lnk; e_ex = n_ex;
    chk("R1", {31'b0, imem_en}, {31'b0, e_en});
    chk(tp, pc, e_pc);
    chk(td, {31'b0, dec_in_slot}, {31'b0, e_dec});
    chk(tx, ex_link_addr, e_lnk);
    chk(tx, {31'b0, ex_in_slot}, {31'b0, e_ex});
  endtask

  task automatic run_free(int k);
    for (int j = 0; j < k; j++) step(1'b0, 6'd0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
  endtask

  initial begin
    logic [31:0] before_redirect;
    void'($urandom(32'd20140922));
    @(negedge clk);
    // reset state
    step(1'b1, 6'd0, 1'b0, 32'h0, 1'b1, 32'hAAAA_5555, 1'b1);
    step(1'b1, 6'd0, 1'b0, 32'h0, 1'b1, 32'hAAAA_5555, 1'b1);
    // release: enable up, first fetch address 0 then sequential
    run_free(3);
    // branch at 4 in decode while 8 is fetched: next PC is the target
    before_redirect = pc;
    step(1'b0, 6'd0, 1'b1, 32'h0000_0100, 1'b1, 32'h0000_000C, 1'b0);
    chk("R5", before_redirect, 32'h0000_0008);
    chk("R5", pc, 32'h0000_0100);
    run_free(1);
    // redirect held during a fetch stall
    for (int j = 0; j < 3; j++)
      step(1'b0, 6'b000001, 1'b1, 32'h0000_0200, 1'b0, 32'h0, 1'b0);
    chk("R12", pc, 32'h0000_0104);
    step(1'b0, 6'd0, 1'b1, 32'h0000_0200, 1'b0, 32'h0, 1'b0);
    chk("R12", pc, 32'h0000_0200);
    // slot flags: load, bubble, full hold
    step(1'b0, 6'd0, 1'b0, 32'h0, 1'b1, 32'h1234_5678, 1'b1);
    step(1'b0, 6'b001100, 1'b0, 32'h0, 1'b0, 32'hDEAD_BEEF, 1'b0);
    step(1'b0, 6'b000100, 1'b0, 32'h0, 1'b0, 32'hDEAD_BEEF, 1'b0);
    chk("R9", ex_link_addr, 32'h0);
    chk("R7", {31'b0, dec_in_slot}, 32'h1);
    // constrained random mix
    for (int j = 0; j < 600; j++) begin
      logic [5:0] s;
      s = 6'($urandom & $urandom);
      step(($urandom_range(0, 63) == 0), s, ($urandom_range(0, 3) == 0),
           $urandom & 32'hFFFF_FFFC, 1'($urandom), $urandom, 1'($urandom));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule